// File: doc/BRIEF.md
# Staged-Commit Transmit Byte Queue

This block is the transmit buffer of a serial port. It holds 1024 bytes. The host writes bytes through a word-wide memory window into staging space that begins at the current write pointer. Those bytes stay invisible to the downstream transmitter until the host writes a byte count to the commit port. The commit then advances the write pointer and the fill count together.

A status word carries the write pointer and the committed fill count. The host reads the pointer so it can keep its 32-bit writes aligned, and it reads the count to know how much room is left. The host treats 1020 bytes as the usable capacity. A commit that asks for more than the free room is clamped to the free room and latches an error flag.

Committed bytes leave in order on a byte-wide valid/ready stream toward a serial transmitter. A programmable level gives a one-cycle space event when the fill count drops below it, and an empty flag shows that nothing committed remains.

Top module: `stage_commit_txq`

## Requirements
- R1: After synchronous reset, `ctrl_rdata` reads 0, `empty` is 1, `tx_valid` is 0, `commit_err` is 0 and `space_evt` is 0.
- R2: `ctrl_rdata` carries the write pointer in bits [9:0] and the committed fill count in bits [25:16]. All other bits read 0.
- R3: A window write at word offset k places lane i (`win_wdata[8i+7:8i]`) at buffer address (write pointer + 4k + i) mod 1024. Staged bytes change neither the fill count nor `tx_valid` until they are committed.
- R4: A commit of N bytes, with N no larger than the free room, advances both the write pointer and the fill count by N. The new values are visible in the cycle after the commit.
- R5: When the requested N exceeds 1020 minus the fill count, only the free room is committed. `commit_err` then goes high and stays high until reset.
- R6: `tx_valid` is high while the fill count is nonzero. `tx_data` is the oldest committed byte. Each cycle with `tx_valid` and `tx_ready` both high removes one byte and lowers the fill count by one, and bytes leave in commit order.
- R7: `empty` is 1 exactly when the fill count is 0.
- R8: A level code n on `level_code` selects a threshold of 4·2^n bytes. `space_evt` is high for a single cycle: the first cycle in which the fill count reads below the threshold after reading at or above it.
- R9: The write pointer, the read position and the window addresses all wrap modulo 1024, so data staged across the end of the buffer comes out intact.
- R10: A commit of N in the same cycle as an accepted pop leaves the fill count at its old value plus N minus 1.
- R11: A window lane whose byte enable is 0 leaves that buffer byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_we | input | 1 | Window word write strobe |
| win_word_off | input | 8 | Word offset of the write, relative to the write pointer |
| win_wdata | input | 32 | Window write data, four byte lanes |
| win_be | input | 4 | Byte enables, one per lane |
| commit_we | input | 1 | Commit strobe |
| commit_cnt | input | 10 | Number of staged bytes to commit |
| level_code | input | 3 | Space threshold code |
| ctrl_rdata | output | 32 | Status word: write pointer and fill count |
| tx_data | output | 8 | Oldest committed byte |
| tx_valid | output | 1 | A committed byte is available |
| tx_ready | input | 1 | Transmitter accepts the byte |
| space_evt | output | 1 | One-cycle pulse on falling below the threshold |
| empty | output | 1 | Fill count is zero |
| commit_err | output | 1 | Sticky flag: a commit was clamped |

## Verification
The bench builds the block with its defaults: a 10-bit address (1024 bytes) and a usable capacity of 1020. With these values the bench can fill the buffer to its real limit, so clamping happens at exactly 1020. It can also steer the write pointer to 1022, so that one staged burst crosses the end of the buffer. Level code 0, a 4-byte threshold, makes the single space pulse observable within a short drain.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int TXQ_AW    = 10;
    localparam int TXQ_SLACK = 4;
    localparam int TXQ_LANES = 4;

    typedef struct packed {
        logic [31:0] data;
        logic [3:0]  be;
    } win_beat_t;

    // Threshold in bytes for a level code: 4 * 2^code.
    function automatic logic [TXQ_AW:0] level_bytes(input logic [2:0] code);
        return (TXQ_AW + 1)'(4) << code;
    endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store
    import txq_pkg::*;
#(
    parameter int AW  = TXQ_AW,
    parameter int WAW = AW - 2
) (
    input  logic           clk,
    input  logic           we,
    input  logic [WAW-1:0] word_off,
    input  win_beat_t      beat,
    input  logic [AW-1:0]  wptr,
    input  logic [AW-1:0]  rd_addr,
    output logic [7:0]     rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] lane_addr [TXQ_LANES];

    for (genvar g = 0; g < TXQ_LANES; g++) begin : g_lane
        assign lane_addr[g] = wptr + {word_off, 2'b00} + AW'(g);
    end

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < TXQ_LANES; i++) begin
                if (beat.be[i]) mem[lane_addr[i]] <= beat.data[8*i +: 8];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/txq_ptrs.sv
module txq_ptrs
    import txq_pkg::*;
#(
    parameter int AW     = TXQ_AW,
    parameter int USABLE = (1 << AW) - TXQ_SLACK
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit_we,
    input  logic [AW-1:0] commit_cnt,
    input  logic          pop,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [AW-1:0] fill,
    output logic          err
);
    localparam int CW = AW + 1;

    logic [CW-1:0] free_room, req, take, fill_next;
    logic          over;

    always_comb begin
        free_room = CW'(USABLE) - {1'b0, fill};
        req       = {1'b0, commit_cnt};
        over      = commit_we && (req > free_room);
        take      = commit_we ? (over ? free_room : req) : '0;
        fill_next = {1'b0, fill} + take - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
            err  <= 1'b0;
        end else begin
            wptr <= wptr + take[AW-1:0];
            rptr <= rptr + AW'(pop);
            fill <= fill_next[AW-1:0];
            err  <= err | over;
        end
    end

    AST_FILL_CAP: assert property (@(posedge clk) disable iff (rst)
        fill <= AW'(USABLE)); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R5

    AST_COMMIT_ADV: assert property (@(posedge clk) disable iff (rst)
        (commit_we && !pop && ({1'b0, commit_cnt} <= free_room))
        |=> (fill == $past(fill) + $past(commit_cnt)) && (wptr == $past(wptr) + $past(commit_cnt))); // R4

    AST_POP_DEC: assert property (@(posedge clk) disable iff (rst)
        (pop && !commit_we) |=> (fill == $past(fill) - 1'b1)); // R6

    AST_PTR_GAP: assert property (@(posedge clk) disable iff (rst)
        AW'(wptr - rptr) == fill); // R9

endmodule

// File: rtl/txq_space.sv
module txq_space
    import txq_pkg::*;
#(
    parameter int AW = TXQ_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] fill,
    input  logic [2:0]    level_code,
    output logic          evt
);
    logic [AW:0] thr;
    logic        below, below_d;

    assign thr   = level_bytes(level_code);
    assign below = {1'b0, fill} < thr;

    always_ff @(posedge clk) begin
        if (rst) below_d <= 1'b1;
        else     below_d <= below;
    end

    assign evt = below & ~below_d;

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt); // R8

endmodule

// File: rtl/stage_commit_txq.sv
module stage_commit_txq
    import txq_pkg::*;
#(
    parameter int AW     = TXQ_AW,
    parameter int USABLE = (1 << AW) - TXQ_SLACK,
    parameter int WAW    = AW - 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           win_we,
    input  logic [WAW-1:0] win_word_off,
    input  logic [31:0]    win_wdata,
    input  logic [3:0]     win_be,
    input  logic           commit_we,
    input  logic [AW-1:0]  commit_cnt,
    input  logic [2:0]     level_code,
    output logic [31:0]    ctrl_rdata,
    output logic [7:0]     tx_data,
    output logic           tx_valid,
    input  logic           tx_ready,
    output logic           space_evt,
    output logic           empty,
    output logic           commit_err
);
    logic [AW-1:0] wptr, rptr, fill;
    logic          pop;
    win_beat_t     beat;

    assign beat = '{data: win_wdata, be: win_be};

    txq_store #(.AW(AW), .WAW(WAW)) u_store (
        .clk      (clk),
        .we       (win_we),
        .word_off (win_word_off),
        .beat     (beat),
        .wptr     (wptr),
        .rd_addr  (rptr),
        .rd_data  (tx_data)
    );

    txq_ptrs #(.AW(AW), .USABLE(USABLE)) u_ptrs (
        .clk        (clk),
        .rst        (rst),
        .commit_we  (commit_we),
        .commit_cnt (commit_cnt),
        .pop        (pop),
        .wptr       (wptr),
        .rptr       (rptr),
        .fill       (fill),
        .err        (commit_err)
    );

    txq_space #(.AW(AW)) u_space (
        .clk        (clk),
        .rst        (rst),
        .fill       (fill),
        .level_code (level_code),
        .evt        (space_evt)
    );

    assign tx_valid = (fill != '0);
    assign empty    = (fill == '0);
    assign pop      = tx_valid & tx_ready;

    always_comb begin
        ctrl_rdata           = '0;
        ctrl_rdata[AW-1:0]   = wptr;
        ctrl_rdata[16 +: AW] = fill;
    end

    AST_STAGE_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        (!commit_we && !pop) |=> $stable(ctrl_rdata)); // R3

    AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (rst)
        empty |=> (ctrl_rdata[16 +: AW] <= $past(commit_cnt))); // R7

endmodule

// File: tb/stage_commit_txq_bench.sv
module stage_commit_txq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        win_we;
    logic [7:0]  win_word_off;
    logic [31:0] win_wdata;
    logic [3:0]  win_be;
    logic        commit_we;
    logic [9:0]  commit_cnt;
    logic [2:0]  level_code;
    logic [31:0] ctrl_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_ready, space_evt, empty, commit_err;

    always #2 clk = ~clk;

    stage_commit_txq u_stage_commit_txq (
        .clk(clk), .rst(rst), .win_we(win_we), .win_word_off(win_word_off),
        .win_wdata(win_wdata), .win_be(win_be), .commit_we(commit_we),
        .commit_cnt(commit_cnt), .level_code(level_code), .ctrl_rdata(ctrl_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .space_evt(space_evt), .empty(empty), .commit_err(commit_err)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] shadow [1024];
    logic [7:0] q [$];
    int  m_wptr = 0;
    int  m_fill = 0;
    bit  m_err  = 0;
    int  m_thr  = 128;
    int  evt_seen = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl();
        return (32'(m_fill) << 16) | 32'(m_wptr);
    endfunction

    task automatic wr_word(input int off, input logic [31:0] d, input logic [3:0] be);
        win_we = 1'b1; win_word_off = 8'(off); win_wdata = d; win_be = be;
        @(negedge clk);
        win_we = 1'b0; win_be = 4'h0;
        for (int i = 0; i < 4; i++)
            if (be[i]) shadow[(m_wptr + 4*off + i) % 1024] = d[8*i +: 8];
    endtask

    task automatic do_commit(input int n);
        int take;
        take = (n > 1020 - m_fill) ? 1020 - m_fill : n;
        if (n > 1020 - m_fill) m_err = 1;
        commit_we = 1'b1; commit_cnt = 10'(n);
        @(negedge clk);
        commit_we = 1'b0;
        for (int i = 0; i < take; i++) q.push_back(shadow[(m_wptr + i) % 1024]);
        m_wptr = (m_wptr + take) % 1024;
        m_fill += take;
        chk("R4 ctrl after commit", ctrl_rdata, exp_ctrl());
        chk("R2 reserved bits zero", {ctrl_rdata[31:26], ctrl_rdata[15:10]}, 32'h0);
        chk("R5 error flag", 32'(commit_err), 32'(m_err));
    endtask

    task automatic drain(input int n, input bit chk_evt);
        int last;
        last = m_fill;
        tx_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            chk("R6 valid", 32'(tx_valid), 32'h1);
            if (!$isunknown(q[0])) chk("R6 data order", 32'(tx_data), 32'(q[0]));
            if (chk_evt) begin
                chk("R8 space pulse", 32'(space_evt), 32'((m_fill < m_thr) && (last >= m_thr)));
                if (space_evt) evt_seen++;
            end
            last = m_fill;
            @(negedge clk);
            void'(q.pop_front());
            m_fill--;
        end
        tx_ready = 1'b0;
        if (chk_evt) begin
            chk("R8 space pulse after", 32'(space_evt), 32'((m_fill < m_thr) && (last >= m_thr)));
            if (space_evt) evt_seen++;
        end
        chk("R6 fill after drain", ctrl_rdata, exp_ctrl());
    endtask

    task automatic t_reset();
        chk("R1 ctrl", ctrl_rdata, 32'h0);
        chk("R1 empty", 32'(empty), 32'h1);
        chk("R1 valid", 32'(tx_valid), 32'h0);
        chk("R1 err", 32'(commit_err), 32'h0);
        chk("R1 evt", 32'(space_evt), 32'h0);
    endtask

    task automatic t_stage_commit();
        wr_word(0, 32'h13121110, 4'hF);
        wr_word(1, 32'h17161514, 4'hF);
        chk("R3 staged hidden ctrl", ctrl_rdata, 32'h0);
        chk("R3 staged hidden valid", 32'(tx_valid), 32'h0);
        do_commit(8);
        chk("R2 ctrl layout", ctrl_rdata, 32'h0008_0008);
        chk("R7 not empty", 32'(empty), 32'h0);
        drain(8, 0);
        chk("R7 empty again", 32'(empty), 32'h1);
    endtask

    task automatic t_byte_enable();
        wr_word(0, 32'h44332211, 4'hF);
        wr_word(0, 32'hAABBCCDD, 4'b0101);
        do_commit(4);
        chk("R11 lane0", 32'(q[0]), 32'hDD);
        chk("R11 lane1 kept", 32'(q[1]), 32'h22);
        chk("R11 lane3 kept", 32'(q[3]), 32'h44);
        drain(4, 0);
    endtask

    task automatic t_unaligned();
        wr_word(0, 32'h03020100, 4'hF);
        do_commit(3);
        chk("R3 unaligned wptr", 32'(ctrl_rdata[9:0]), 32'(m_wptr));
        wr_word(0, 32'h0B0A0908, 4'hF);
        do_commit(4);
        drain(7, 0);
    endtask

    task automatic t_space_event();
        level_code = 3'd0; m_thr = 4;
        @(negedge clk);
        wr_word(0, 32'h33221100, 4'hF);
        wr_word(1, 32'h77665544, 4'hF);
        do_commit(6);
        evt_seen = 0;
        drain(6, 1);
        chk("R8 exactly one pulse", 32'(evt_seen), 32'h1);
    endtask

    task automatic t_concurrent();
        wr_word(0, 32'hC3C2C1C0, 4'hF);
        do_commit(4);
        wr_word(0, 32'hD3D2D1D0, 4'hF);
        chk("R10 head byte", 32'(tx_data), 32'hC0);
        commit_we = 1'b1; commit_cnt = 10'd4; tx_ready = 1'b1;
        @(negedge clk);
        commit_we = 1'b0; tx_ready = 1'b0;
        void'(q.pop_front()); m_fill--;
        for (int i = 0; i < 4; i++) q.push_back(shadow[(m_wptr + i) % 1024]);
        m_wptr = (m_wptr + 4) % 1024; m_fill += 4;
        chk("R10 fill plus n minus one", 32'(ctrl_rdata[25:16]), 32'd7);
        drain(m_fill, 0);
    endtask

    task automatic t_clamp();
        do_commit(1023);
        chk("R5 clamped fill", 32'(ctrl_rdata[25:16]), 32'd1020);
        chk("R5 err set", 32'(commit_err), 32'h1);
        do_commit(5);
        chk("R5 full stays", 32'(ctrl_rdata[25:16]), 32'd1020);
        drain(1020, 0);
        chk("R5 err sticky", 32'(commit_err), 32'h1);
    endtask

    task automatic t_wrap();
        int k;
        k = (1022 - m_wptr + 1024) % 1024;
        while (k > 0) begin
            int c;
            c = (k > 1000) ? 1000 : k;
            do_commit(c);
            drain(c, 0);
            k -= c;
        end
        chk("R9 wptr near end", 32'(ctrl_rdata[9:0]), 32'd1022);
        wr_word(0, 32'h5A5B5C5D, 4'hF);
        wr_word(1, 32'h6A6B6C6D, 4'hF);
        do_commit(8);
        chk("R9 wptr wrapped", 32'(ctrl_rdata[9:0]), 32'd6);
        chk("R9 byte at 1022", 32'(tx_data), 32'h5D);
        drain(8, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) shadow[i] = 8'hxx;
        rst = 1'b1; win_we = 1'b0; win_word_off = '0; win_wdata = '0; win_be = '0;
        commit_we = 1'b0; commit_cnt = '0; level_code = 3'd5; tx_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_stage_commit();
        t_byte_enable();
        t_unaligned();
        t_space_event();
        t_concurrent();
        t_clamp();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule